// File: doc/BRIEF.md
# Sound Command Interrupt Latch

This block raises the interrupt request that a main processor sends to a sound processor. The main side writes a byte to a control register. In the default latched mode, one bit of that byte acts as the clock of an edge-triggered request flop. The flop sets when that bit falls from 1 to 0 between consecutive writes. The flop's inverted output drives the sound processor's active-low interrupt line. The sound processor's interrupt acknowledge clears the request. During the acknowledge, the block drives a fixed vector byte.

Another bit of the same control byte is a global sound-disable control. When it is 1, the sound-enable output drops.

A parameter selects a second, direct mode. In that mode any control write raises the request, and a read strobe on the command latch drops it. When a set and a clear fall in the same cycle, the clear wins in either mode.

Top module: `sndirq_top`

## Requirements
- R1: After reset, irqN is 1, sndEnable is 1 and ackVector is 0x00.
- R2: In latched mode, a write whose bit 3 is 0 raises the request (irqN goes 0 on the cycle after the write) when the bit 3 stored by the previous write was 1.
- R3: In latched mode, a write whose bit 3 stays 0, stays 1 or rises leaves irqN unchanged. A pending request holds across any number of such writes.
- R4: In latched mode, irqAck drops the request, so irqN is 1 on the cycle after the acknowledge. cmdRd has no effect on irqN.
- R5: In both modes, ackVector equals VECTOR (default 0xFF) in any cycle where irqAck is 1, and 0x00 otherwise.
- R6: In both modes, sndEnable takes the inverse of bit 4 of the most recent write, from the cycle after that write.
- R7: In direct mode, every write makes irqN 0 on the next cycle, and cmdRd makes it 1 on the next cycle. irqAck has no effect on irqN.
- R8: When a set and a clear arrive in the same cycle, irqN is 1 on the next cycle.
- R9: The stored bit 3 resets to 0. In latched mode, the first write after reset cannot raise a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlWr | input | 1 | Control register write strobe |
| ctlData | input | 8 | Control byte (bit 3 request clock, bit 4 sound disable) |
| irqAck | input | 1 | Interrupt acknowledge from the sound processor |
| cmdRd | input | 1 | Command latch read strobe from the sound processor |
| irqN | output | 1 | Active-low interrupt request |
| sndEnable | output | 1 | Global sound enable |
| ackVector | output | 8 | Vector byte driven during acknowledge |

## Verification
One latched-mode instance and one direct-mode instance receive identical strobes. Directed sequences walk bit 3 through its four transitions (0→0, 0→1, 1→0, 1→1), so that only a true fall sets the latched request while every write sets the direct one. Other directed cases place a set and a clear in the same cycle, and send the strobe that each mode must ignore (read in latched mode, acknowledge in direct mode). Random cycles then mix writes, acknowledges and reads. These cycles expose a request that is missed, lost early or cleared by the wrong strobe, and a sound-enable bit taken from the wrong write.

// File: rtl/sndirq_pkg.sv
package sndirq_pkg;
  // Strobes from the control decode to the request datapath
  typedef struct packed {
    logic setReq;
    logic clrReq;
  } reqStrobeT;
endpackage

// File: rtl/sndirq_ctrl.sv
module sndirq_ctrl
  import sndirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CLK_BIT = 3,
  parameter int DIS_BIT = 4,
  parameter bit DIRECT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWr,
  input  logic [DATA_W-1:0] ctlData,
  input  logic              irqAck,
  input  logic              cmdRd,
  output reqStrobeT         strb,
  output logic              sndEnable
);
  logic clkBitQ;
  logic disableQ;
  logic fallEdge;
  logic unusedData;

  assign unusedData = ^ctlData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkBitQ  <= 1'b0;
      disableQ <= 1'b0;
    end else if (ctlWr) begin
      clkBitQ  <= ctlData[CLK_BIT];
      disableQ <= ctlData[DIS_BIT];
    end
  end

  // Inverted bit acts as the flop clock: rising of the inverse = falling of the bit
  assign fallEdge = ctlWr && clkBitQ && !ctlData[CLK_BIT];

  generate
    if (DIRECT_MODE) begin : g_direct
      logic unusedStrb;
      assign unusedStrb = fallEdge ^ irqAck;
      always_comb begin
        strb.setReq = ctlWr;
        strb.clrReq = cmdRd;
      end
    end else begin : g_edge
      logic unusedStrb;
      assign unusedStrb = cmdRd;
      always_comb begin
        strb.setReq = fallEdge;
        strb.clrReq = irqAck;
      end
    end
  endgenerate

  assign sndEnable = !disableQ;

  // R6: enable only moves after a write
  a_r6_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctlWr |=> $stable(sndEnable));
  // R6: enable follows the disable bit of the write
  a_r6_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWr |=> (sndEnable == !$past(ctlData[DIS_BIT])));
endmodule

// File: rtl/sndirq_dp.sv
module sndirq_dp
  import sndirq_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VECTOR = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reqStrobeT        strb,
  input  logic             irqAck,
  output logic             irqN,
  output logic [VEC_W-1:0] ackVector
);
  logic reqQ;

  // D tied high, preset idle: set loads 1, clear has priority
  always_ff @(posedge clk) begin
    if (!rst_n)            reqQ <= 1'b0;
    else if (strb.clrReq)  reqQ <= 1'b0;
    else if (strb.setReq)  reqQ <= 1'b1;
  end

  assign irqN      = !reqQ;
  assign ackVector = irqAck ? VECTOR : '0;

  // R2 / R7: set without clear asserts the line next cycle
  a_r2_set_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setReq && !strb.clrReq) |=> !irqN);
  // R8: clear wins
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrReq |=> irqN);
  // R3: line holds without strobes
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.setReq && !strb.clrReq) |=> $stable(irqN));
  // R5: vector present during acknowledge
  a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irqAck |-> (ackVector == VECTOR));
endmodule

// File: rtl/sndirq_top.sv
module sndirq_top
  import sndirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CLK_BIT = 3,
  parameter int DIS_BIT = 4,
  parameter logic [DATA_W-1:0] VECTOR = '1,
  parameter bit DIRECT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctlWr,
  input  logic [DATA_W-1:0] ctlData,
  input  logic              irqAck,
  input  logic              cmdRd,
  output logic              irqN,
  output logic              sndEnable,
  output logic [DATA_W-1:0] ackVector
);
  reqStrobeT strb;

  sndirq_ctrl #(
    .DATA_W(DATA_W), .CLK_BIT(CLK_BIT), .DIS_BIT(DIS_BIT), .DIRECT_MODE(DIRECT_MODE)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ctlWr(ctlWr), .ctlData(ctlData),
    .irqAck(irqAck), .cmdRd(cmdRd), .strb(strb), .sndEnable(sndEnable)
  );

  sndirq_dp #(.VEC_W(DATA_W), .VECTOR(VECTOR)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .irqAck(irqAck),
    .irqN(irqN), .ackVector(ackVector)
  );
endmodule

// File: tb/sndirq_tb.sv
`timescale 1ns/1ps
module sndirq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctlWr = 1'b0;
  logic [7:0] ctlData = 8'h00;
  logic irqAck = 1'b0;
  logic cmdRd = 1'b0;
  logic irqNL, sndEnL, irqND, sndEnD;
  logic [7:0] vecL, vecD;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // model state
  bit qL, prevL, disL, qD, disD;

  always #5 clk = ~clk;

  sndirq_top #(.DIRECT_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctlWr(ctlWr), .ctlData(ctlData), .irqAck(irqAck),
    .cmdRd(cmdRd), .irqN(irqNL), .sndEnable(sndEnL), .ackVector(vecL));

  sndirq_top #(.DIRECT_MODE(1'b1)) dut_direct_i (
    .clk(clk), .rst_n(rst_n), .ctlWr(ctlWr), .ctlData(ctlData), .irqAck(irqAck),
    .cmdRd(cmdRd), .irqN(irqND), .sndEnable(sndEnD), .ackVector(vecD));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit nextQ(bit q, bit setR, bit clrR);
    return clrR ? 1'b0 : (setR ? 1'b1 : q);
  endfunction

  // one cycle: drive at negedge, check vector, check registered results next negedge
  task automatic cyc(bit wr, logic [7:0] d, bit ack, bit rd);
    bit setL, setD;
    string tagL, tagD;
    ctlWr = wr; ctlData = d; irqAck = ack; cmdRd = rd;
    #1;
    chk("R5 vector latched", vecL, ack ? 8'hFF : 8'h00);
    chk("R5 vector direct", vecD, ack ? 8'hFF : 8'h00);
    setL = wr && prevL && !d[3];
    setD = wr;
    tagL = (setL && ack) ? "R8 latched" : ack ? "R4 ack clear" : setL ? "R2 fall set" :
           rd ? "R4 read ignored" : "R3 hold";
    tagD = (setD && rd) ? "R8 direct" : "R7 direct";
    qL = nextQ(qL, setL, ack);
    qD = nextQ(qD, setD, rd);
    if (wr) begin prevL = d[3]; disL = d[4]; disD = d[4]; end
    @(posedge clk);
    @(negedge clk);
    ctlWr = 1'b0; irqAck = 1'b0; cmdRd = 1'b0;
    chk(tagL, irqNL, !qL);
    chk(tagD, irqND, !qD);
    chk("R6 enable latched", sndEnL, !disL);
    chk("R6 enable direct", sndEnD, !disD);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irqN latched", irqNL, 1);
    chk("R1 irqN direct", irqND, 1);
    chk("R1 enable", sndEnL, 1);
    chk("R1 vector", vecL, 0);
    qL = 0; prevL = 0; disL = 0; qD = 0; disD = 0;
    @(negedge clk);
    // R9: first write with bit 3 low after reset raises nothing
    cyc(1, 8'h00, 0, 0);
    chk("R9 no request after reset", irqNL, 1);
    cyc(1, 8'h08, 0, 0);          // R3 rise
    cyc(1, 8'h00, 0, 0);          // R2 fall
    chk("R2 request raised", irqNL, 0);
    cyc(1, 8'h00, 0, 0);          // R3 stay low
    cyc(1, 8'h08, 0, 0);          // R3 rise, still pending
    chk("R3 still pending", irqNL, 0);
    cyc(0, 8'h00, 0, 1);          // R4 read ignored in latched mode
    chk("R4 read ignored", irqNL, 0);
    chk("R7 read clears direct", irqND, 1);
    cyc(0, 8'h00, 1, 0);          // R4 ack clears
    chk("R4 acknowledged", irqNL, 1);
    cyc(1, 8'h08, 0, 0);
    cyc(0, 8'h00, 1, 0);          // R7 ack ignored in direct mode
    chk("R7 ack ignored", irqND, 0);
    cyc(1, 8'h00, 1, 1);          // R8 set and clear together
    chk("R8 clear wins latched", irqNL, 1);
    chk("R8 clear wins direct", irqND, 1);
    cyc(1, 8'h18, 0, 0);          // R6 disable
    chk("R6 disabled", sndEnL, 0);
    cyc(1, 8'h00, 0, 0);          // R6 enable plus R2 fall
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cyc(($urandom % 3) != 0, d, ($urandom % 5) == 0, ($urandom % 5) == 0);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule